// File: doc/BRIEF.md
# Stack Pointer Offset Tracker

This issue-stage unit takes over the implicit stack-pointer arithmetic of push, pop, call and return. It keeps a small signed running offset from the architectural stack pointer, so none of these instructions needs an add or subtract uop in the out-of-order core. Each stack instruction leaves the unit as one memory uop. That uop carries the displacement from the stack pointer to the slot it touches.

The unit accepts one classified instruction per cycle over a valid/ready handshake. It presents one uop per cycle on its output, which uses the same handshake. It injects a synchronisation uop in two cases. The first is an adjustment that would push the offset out of its signed range. The second is a non-stack instruction that reads or writes the stack pointer itself while the offset is non-zero. The sync uop carries the accumulated offset for the core to add into the stack pointer. The tracker then restarts from zero and issues the held instruction on the following cycle. A flush input discards the offset at once.

Top module: `stk_ofs_tracker`

## Requirements
- R1: A push (in_kind 1) or call (in_kind 3) that fits the range lowers the offset by STEP. It is emitted as one store uop (out_kind 2) whose out_disp is the lowered offset.
- R2: A pop (in_kind 2) or return (in_kind 4) that fits the range is emitted as a single load uop (out_kind 1). Its out_disp is the offset before the update, and the offset then rises by STEP.
- R3: Suppose an adjustment would take the offset outside the signed OFS_W-bit range. A sync uop (out_kind 0) is then emitted first, carrying the current offset. The offset becomes zero and the stack instruction issues on the next cycle against that zero.
- R4: An explicit stack-pointer read (in_kind 5) or write (in_kind 6) arriving with a non-zero offset is preceded by a sync uop carrying the offset. The instruction then passes through (out_kind 3) with out_disp 0.
- R5: An explicit stack-pointer read or write arriving with a zero offset passes through directly, and no sync uop is produced.
- R6: While a sync uop is on the output, in_ready is low and the triggering instruction is not consumed.
- R7: Any other instruction (in_kind 0 or 7) passes through as out_kind 3 with out_disp 0, and it leaves the offset unchanged.
- R8: While out_ready is low, in_ready is low and the offset does not change.
- R9: While flush is high, out_valid and in_ready are low. The offset is zero on the next cycle, so no sync is pending afterwards.
- R10: During reset and directly after it, the offset is zero, and out_valid and in_ready are low while reset is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Pipeline flush, clears the offset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Instruction consumed this cycle |
| in_kind | input | 3 | Instruction class |
| in_tag | input | TAG_W | Opaque instruction tag |
| out_valid | output | 1 | Uop present |
| out_ready | input | 1 | Downstream accepts the uop |
| out_kind | output | 2 | Uop type: 0 sync, 1 load, 2 store, 3 pass |
| out_disp | output | OFS_W | Signed displacement from the stack pointer |
| out_tag | output | TAG_W | Tag of the instruction behind the uop |

## Verification
The bench builds the tracker with OFS_W = 6 and STEP = 4. With these values the range is -32 to 31, and the overflow boundary is eight pushes or seven pops away from zero. Long runs of pushes and pops therefore cross both edges of the range several times within a short test. Directed sequences check back-pressure, flush, and direct stack-pointer use at zero and non-zero offsets. A pseudo-random mix of all instruction classes then runs against an arithmetic model of the offset.

// File: rtl/stk_ofs_pkg.sv
package stk_ofs_pkg;

  typedef enum logic [2:0] {
    IK_OTHER    = 3'd0,
    IK_PUSH     = 3'd1,
    IK_POP      = 3'd2,
    IK_CALL     = 3'd3,
    IK_RET      = 3'd4,
    IK_SP_READ  = 3'd5,
    IK_SP_WRITE = 3'd6,
    IK_SPARE    = 3'd7
  } ins_kind_e;

  typedef enum logic [1:0] {
    UK_SYNC  = 2'd0,
    UK_LOAD  = 2'd1,
    UK_STORE = 2'd2,
    UK_PASS  = 2'd3
  } uop_kind_e;

endpackage

// File: rtl/stk_ofs_rst_sync.sv
module stk_ofs_rst_sync (
  input  logic clk,
  input  logic rst_n_a,
  output logic rst_n_s
);
  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n_a) begin
    if (!rst_n_a) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_n_s = hold_q;
endmodule

// File: rtl/stk_ofs_decide.sv
module stk_ofs_decide
  import stk_ofs_pkg::*;
#(
  parameter int OFS_W = 8,
  parameter int STEP  = 8
) (
  input  ins_kind_e               kind,
  input  logic signed [OFS_W-1:0] ofs_cur,
  output logic                    need_sync,
  output uop_kind_e               ukind,
  output logic signed [OFS_W-1:0] disp,
  output logic signed [OFS_W-1:0] ofs_after
);
  localparam int EXT_W = OFS_W + 2;
  localparam logic signed [EXT_W-1:0] LIM_HI = EXT_W'((2 ** (OFS_W - 1)) - 1);
  localparam logic signed [EXT_W-1:0] LIM_LO = -EXT_W'(2 ** (OFS_W - 1));
  localparam logic signed [EXT_W-1:0] STEP_X = EXT_W'(STEP);

  logic signed [EXT_W-1:0] ofs_x;
  logic signed [EXT_W-1:0] dn_x;
  logic signed [EXT_W-1:0] up_x;
  logic                    dn_over;
  logic                    up_over;
  logic                    ofs_nz;

  always_comb begin
    ofs_x   = {{2{ofs_cur[OFS_W-1]}}, ofs_cur};
    dn_x    = ofs_x - STEP_X;
    up_x    = ofs_x + STEP_X;
    dn_over = (dn_x < LIM_LO);
    up_over = (up_x > LIM_HI);
    ofs_nz  = (ofs_cur != '0);
  end

  always_comb begin
    need_sync = 1'b0;
    ukind     = UK_PASS;
    disp      = '0;
    ofs_after = ofs_cur;
    unique case (kind)
      IK_PUSH, IK_CALL: begin
        if (dn_over) begin
          need_sync = 1'b1;
        end else begin
          ukind     = UK_STORE;
          disp      = dn_x[OFS_W-1:0];
          ofs_after = dn_x[OFS_W-1:0];
        end
      end
      IK_POP, IK_RET: begin
        if (up_over) begin
          need_sync = 1'b1;
        end else begin
          ukind     = UK_LOAD;
          disp      = ofs_cur;
          ofs_after = up_x[OFS_W-1:0];
        end
      end
      IK_SP_READ, IK_SP_WRITE: begin
        need_sync = ofs_nz;
      end
      default: begin
        need_sync = 1'b0;
      end
    endcase
    if (need_sync) begin
      ukind     = UK_SYNC;
      disp      = ofs_cur;
      ofs_after = '0;
    end
  end
endmodule

// File: rtl/stk_ofs_acc.sv
module stk_ofs_acc #(
  parameter int OFS_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flush,
  input  logic                    upd_en,
  input  logic signed [OFS_W-1:0] ofs_nxt,
  output logic signed [OFS_W-1:0] ofs_q
);
  logic                    acc_en;
  logic signed [OFS_W-1:0] acc_d;

  always_comb begin
    acc_en = flush | upd_en;
    acc_d  = flush ? '0 : ofs_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ofs_q <= '0;
    end else if (acc_en) begin
      ofs_q <= acc_d;
    end
  end
endmodule

// File: rtl/stk_ofs_tracker.sv
module stk_ofs_tracker
  import stk_ofs_pkg::*;
#(
  parameter int OFS_W = 8,
  parameter int STEP  = 8,
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [2:0]       in_kind,
  input  logic [TAG_W-1:0] in_tag,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [1:0]       out_kind,
  output logic [OFS_W-1:0] out_disp,
  output logic [TAG_W-1:0] out_tag
);
  logic                    rst_n_s;
  logic signed [OFS_W-1:0] ofs_q;
  logic signed [OFS_W-1:0] ofs_after;
  logic signed [OFS_W-1:0] disp_w;
  logic                    need_sync;
  uop_kind_e               ukind;
  ins_kind_e               kind_w;
  logic                    fire;

  stk_ofs_rst_sync u_rst (
    .clk     (clk),
    .rst_n_a (rst_n),
    .rst_n_s (rst_n_s)
  );

  assign kind_w = ins_kind_e'(in_kind);

  stk_ofs_decide #(.OFS_W(OFS_W), .STEP(STEP)) u_decide (
    .kind      (kind_w),
    .ofs_cur   (ofs_q),
    .need_sync (need_sync),
    .ukind     (ukind),
    .disp      (disp_w),
    .ofs_after (ofs_after)
  );

  always_comb begin
    out_valid = in_valid & ~flush & rst_n_s;
    fire      = out_valid & out_ready;
    in_ready  = fire & ~need_sync;
    out_kind  = ukind;
    out_disp  = disp_w;
    out_tag   = in_tag;
  end

  stk_ofs_acc #(.OFS_W(OFS_W)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .flush   (flush),
    .upd_en  (fire),
    .ofs_nxt (ofs_after),
    .ofs_q   (ofs_q)
  );
endmodule

// File: rtl/stk_ofs_tracker_chk.sv
module stk_ofs_tracker_chk #(
  parameter int OFS_W = 8,
  parameter int STEP  = 8
) (
  input logic                    clk,
  input logic                    rst_n_s,
  input logic                    flush,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic [1:0]              out_kind,
  input logic [OFS_W-1:0]        out_disp,
  input logic signed [OFS_W-1:0] ofs_q
);
  logic acc;
  assign acc = out_valid & out_ready & ~flush;

  AST_SYNC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n_s)
    (out_valid && out_kind == 2'd0) |-> !in_ready); // R6
  AST_SYNC_NONZERO: assert property (@(posedge clk) disable iff (!rst_n_s)
    (out_valid && out_kind == 2'd0) |-> (out_disp != '0)); // R5
  AST_SYNC_ZEROES: assert property (@(posedge clk) disable iff (!rst_n_s)
    (acc && out_kind == 2'd0) |=> (ofs_q == '0)); // R3
  AST_STORE_TRACKS: assert property (@(posedge clk) disable iff (!rst_n_s)
    (acc && out_kind == 2'd2) |=> (ofs_q == $signed($past(out_disp)))); // R1
  AST_LOAD_TRACKS: assert property (@(posedge clk) disable iff (!rst_n_s)
    (acc && out_kind == 2'd1) |=> (ofs_q == $signed($past(out_disp)) + OFS_W'(STEP))); // R2
  AST_PASS_ZERO: assert property (@(posedge clk) disable iff (!rst_n_s)
    (out_valid && out_kind == 2'd3) |-> (out_disp == '0)); // R7
  AST_STALL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!out_ready && !flush) |=> $stable(ofs_q)); // R8
  AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n_s)
    flush |-> (!out_valid && !in_ready)); // R9
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n_s)
    flush |=> (ofs_q == '0)); // R9
  AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n_s)
    in_ready |-> (in_valid && out_valid)); // R6
endmodule

bind stk_ofs_tracker stk_ofs_tracker_chk #(.OFS_W(OFS_W), .STEP(STEP)) u_chk (
  .clk       (clk),
  .rst_n_s   (rst_n_s),
  .flush     (flush),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_kind  (out_kind),
  .out_disp  (out_disp),
  .ofs_q     (ofs_q)
);

// File: tb/stk_ofs_tracker_bench.sv
`timescale 1ns/1ps
module stk_ofs_tracker_bench;
  localparam int OFS_W = 6;
  localparam int STEP  = 4;
  localparam int TAG_W = 8;
  localparam int LO    = -(1 << (OFS_W - 1));
  localparam int HI    = (1 << (OFS_W - 1)) - 1;

  logic             clk;
  logic             rst_n;
  logic             flush;
  logic             in_valid;
  logic             in_ready;
  logic [2:0]       in_kind;
  logic [TAG_W-1:0] in_tag;
  logic             out_valid;
  logic             out_ready;
  logic [1:0]       out_kind;
  logic [OFS_W-1:0] out_disp;
  logic [TAG_W-1:0] out_tag;

  int checks;
  int fails;
  int model;
  bit finished;

  stk_ofs_tracker #(.OFS_W(OFS_W), .STEP(STEP), .TAG_W(TAG_W)) u_stk_ofs_tracker (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .in_valid(in_valid), .in_ready(in_ready), .in_kind(in_kind), .in_tag(in_tag),
    .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
    .out_disp(out_disp), .out_tag(out_tag)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sdisp();
    return int'($signed(out_disp));
  endfunction

  // Issue one instruction, following any sync uop ahead of it.
  task automatic send(input logic [2:0] k, input logic [TAG_W-1:0] t);
    bit done;
    bit es;
    int ek;
    int ed;
    string rq;
    done = 1'b0;
    for (int it = 0; it < 3 && !done; it++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_kind  = k;
      in_tag   = t;
      #1;
      es = 1'b0; ek = 3; ed = 0; rq = "R7";
      case (k)
        3'd1, 3'd3: begin
          if (model - STEP < LO) begin es = 1'b1; rq = "R3"; end
          else begin ek = 2; ed = model - STEP; rq = "R1"; end
        end
        3'd2, 3'd4: begin
          if (model + STEP > HI) begin es = 1'b1; rq = "R3"; end
          else begin ek = 1; ed = model; rq = "R2"; end
        end
        3'd5, 3'd6: begin
          if (model != 0) begin es = 1'b1; rq = "R4"; end
          else rq = "R5";
        end
        default: ;
      endcase
      if (es) begin ek = 0; ed = model; end
      chk(out_valid == 1'b1, rq, int'(out_valid), 1);
      chk(int'(out_kind) == ek, rq, int'(out_kind), ek);
      chk(sdisp() == ed, rq, sdisp(), ed);
      chk(in_ready == !es, es ? "R6" : rq, int'(in_ready), int'(!es));
      chk(out_tag == t, rq, int'(out_tag), int'(t));
      @(posedge clk);
      if (es) model = 0;
      else begin
        if (ek == 2) model = model - STEP;
        if (ek == 1) model = model + STEP;
        done = 1'b1;
      end
    end
    chk(done, "R3", int'(done), 1);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] lcg;
    checks = 0; fails = 0; model = 0; finished = 1'b0;
    rst_n = 1'b0; flush = 1'b0; in_valid = 1'b1; in_kind = 3'd1;
    in_tag = '0; out_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R10", int'(out_valid), 0);
    chk(in_ready == 1'b0, "R10", int'(in_ready), 0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R10: offset zero after reset, so a direct read needs no sync.
    send(3'd5, 8'h01);

    // R1/R3: pushes across the low edge, several times.
    for (int i = 0; i < 20; i++) send((i % 2) ? 3'd3 : 3'd1, 8'(i));
    // R2/R3: pops across the high edge.
    for (int i = 0; i < 40; i++) send((i % 2) ? 3'd4 : 3'd2, 8'(i + 64));

    // R4 then R5: direct writes at non-zero then zero offset.
    send(3'd1, 8'h10);
    send(3'd6, 8'h11);
    send(3'd6, 8'h12);
    // R7: other instructions keep the offset.
    send(3'd1, 8'h13);
    send(3'd0, 8'h14);
    send(3'd7, 8'h15);
    send(3'd5, 8'h16);

    // R8: back-pressure holds the offset.
    send(3'd1, 8'h20);
    send(3'd1, 8'h21);
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_kind = 3'd1; in_tag = 8'h22;
    #1;
    chk(in_ready == 1'b0, "R8", int'(in_ready), 0);
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b1;
    send(3'd5, 8'h23);

    // R9: flush clears the offset.
    send(3'd3, 8'h30);
    send(3'd1, 8'h31);
    @(negedge clk);
    flush = 1'b1; in_valid = 1'b1; in_kind = 3'd5;
    #1;
    chk(out_valid == 1'b0, "R9", int'(out_valid), 0);
    chk(in_ready == 1'b0, "R9", int'(in_ready), 0);
    @(negedge clk);
    flush = 1'b0; in_valid = 1'b0;
    model = 0;
    send(3'd5, 8'h32);

    // Mixed pseudo-random run.
    lcg = 32'h1234_5678;
    for (int i = 0; i < 600; i++) begin
      lcg = lcg * 32'd1103515245 + 32'd12345;
      send(lcg[18:16], lcg[27:20]);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule